// File: doc/BRIEF.md
# MSI Snooping Line Coherence Controller

This block keeps the coherence state of one cache line in a cache that shares a snooping bus with other caches. The line is Modified, Shared or Invalid. The block takes three kinds of input. The first is a processor read or write with a tag-match flag. The second is an eviction command. The third is a transaction seen on the bus from another cache, which is either a read or an intent to write, with an address-match flag. From these it decides the next state of the line. It also decides whether a bus request must go out and whether the line's data must be written back.

A miss sends out a bus request and then waits for a fill-complete pulse. Only then does the line take its new state. While it waits, the line is Invalid and all other input is ignored. Any write to a Shared line puts an invalidating upgrade on the bus, even when no other cache holds a copy. A line held Modified is written back whenever another cache reads it or intends to write it. Data movement, arrays of lines and bus arbitration are outside the block.

Top module: `msi_line_ctrl`

## Requirements
- R1: After synchronous reset the line is Invalid, `busy` is 0, `wb_req` is 0 and `bus_req` is 0. States are encoded as Invalid=00, Shared=01, Modified=10, and 11 never appears.
- R2: A processor read that misses issues a bus read (`bus_req`=01). A miss is `cpu_hit`=0, or any read while the line is Invalid. `busy` is then held with the line Invalid until `fill_done`, and the line then becomes Shared.
- R3: A processor write that misses issues a bus read-for-ownership (`bus_req`=10), holds `busy` until `fill_done`, and the line then becomes Modified.
- R4: A write hit on a Shared line issues an upgrade (`bus_req`=11) and moves the line to Modified at once, without waiting.
- R5: A read or write hit on a Modified line, and a read hit on a Shared line, cause no bus request, no writeback and no state change.
- R6: A matching snooped read moves a Modified line to Shared with `wb_req`. It leaves a Shared line Shared and an Invalid line Invalid.
- R7: A matching snooped intent to write moves a Modified line to Invalid with `wb_req`, and moves a Shared line to Invalid without one.
- R8: An eviction moves the line to Invalid. It raises `wb_req` only when the line was Modified.
- R9: A miss that replaces a valid line with a different tag raises `wb_req` when the old line was Modified, and not when it was Shared.
- R10: When several inputs arrive in the same cycle, a matching snoop wins over an eviction, and an eviction wins over a processor request. The losing inputs have no effect in that cycle.
- R11: While `busy` is 1, snoops and processor requests are ignored. A snoop whose address does not match is ignored, and so is a `fill_done` that arrives while no miss is outstanding.
- R12: `bus_req` and `wb_req` are registered. Each is a one-cycle pulse in the cycle after the input that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request this cycle |
| cpu_write | input | 1 | Request is a write (1) or a read (0) |
| cpu_hit | input | 1 | Request tag matches this line |
| cpu_evict | input | 1 | Evict the line |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_write | input | 1 | Snooped transaction is an intent to write (1) or a read (0) |
| snp_match | input | 1 | Snooped address matches this line |
| fill_done | input | 1 | Outstanding miss has been filled |
| line_state | output | 2 | Current state: 00 I, 01 S, 10 M |
| bus_req | output | 2 | 00 none, 01 read, 10 read-for-ownership, 11 upgrade |
| wb_req | output | 1 | Write back the line's data |
| busy | output | 1 | Miss outstanding |

## Verification
The bench reaches each of the three states and then applies every processor, eviction and snoop pattern to it. The patterns are read and write, each as a hit and as a miss, eviction, a matching snooped read, a matching snooped intent to write, a non-matching snoop, a stray fill, and two collision cases. The hit and miss patterns in each state separate an upgrade from a fetch, and a silent replacement from a dirty one. The snoop patterns separate a writeback that leaves the line Shared from one that invalidates it. The collision patterns confirm the priority order. For each miss, a snoop is injected while the miss is outstanding to show that it is ignored, and the state after the fill is then checked.

// File: rtl/msi_pkg.sv
package msi_pkg;
    localparam int STATE_W = 2;
    localparam int BUS_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_I = 2'b00,
        ST_S = 2'b01,
        ST_M = 2'b10
    } line_st_e;

    typedef enum logic [BUS_W-1:0] {
        BUS_NONE = 2'b00,
        BUS_RD   = 2'b01,
        BUS_RDX  = 2'b10,
        BUS_UPG  = 2'b11
    } bus_op_e;

    typedef enum logic [1:0] {
        PEND_NONE = 2'b00,
        PEND_RD   = 2'b01,
        PEND_WR   = 2'b10
    } pend_e;

    typedef struct packed {
        logic cpu_valid;
        logic cpu_write;
        logic cpu_hit;
        logic evict;
        logic snp_hit;
        logic snp_write;
        logic fill_done;
    } line_evt_t;

    typedef struct packed {
        line_st_e state;
        pend_e    pend;
        bus_op_e  bus;
        logic     wb;
    } line_ctl_t;

    function automatic logic holds_data(line_st_e s);
        return s != ST_I;
    endfunction

    function automatic logic is_dirty(line_st_e s);
        return s == ST_M;
    endfunction
endpackage

// File: rtl/msi_evt_pack.sv
module msi_evt_pack
    import msi_pkg::*;
(
    input  logic      cpu_valid,
    input  logic      cpu_write,
    input  logic      cpu_hit,
    input  logic      cpu_evict,
    input  logic      snp_valid,
    input  logic      snp_write,
    input  logic      snp_match,
    input  logic      fill_done,
    output line_evt_t evt
);
    always_comb begin
        evt.cpu_valid = cpu_valid;
        evt.cpu_write = cpu_write;
        evt.cpu_hit   = cpu_hit;
        evt.evict     = cpu_evict;
        evt.snp_hit   = snp_valid & snp_match;
        evt.snp_write = snp_write;
        evt.fill_done = fill_done;
    end
endmodule

// File: rtl/msi_next_ctl.sv
module msi_next_ctl
    import msi_pkg::*;
(
    input  line_ctl_t cur,
    input  line_evt_t evt,
    output line_ctl_t nxt
);
    logic tag_hit;

    always_comb begin
        tag_hit    = evt.cpu_hit & holds_data(cur.state);
        nxt        = cur;
        nxt.bus    = BUS_NONE;
        nxt.wb     = 1'b0;
        if (cur.pend != PEND_NONE) begin
            if (evt.fill_done) begin
                nxt.state = (cur.pend == PEND_RD) ? ST_S : ST_M;
                nxt.pend  = PEND_NONE;
            end
        end else if (evt.snp_hit) begin
            if (evt.snp_write) begin
                nxt.wb    = is_dirty(cur.state);
                nxt.state = ST_I;
            end else if (is_dirty(cur.state)) begin
                nxt.wb    = 1'b1;
                nxt.state = ST_S;
            end
        end else if (evt.evict) begin
            nxt.wb    = is_dirty(cur.state);
            nxt.state = ST_I;
        end else if (evt.cpu_valid) begin
            if (tag_hit) begin
                if (evt.cpu_write && cur.state == ST_S) begin
                    nxt.bus   = BUS_UPG;
                    nxt.state = ST_M;
                end
            end else begin
                nxt.wb    = is_dirty(cur.state);
                nxt.state = ST_I;
                nxt.pend  = evt.cpu_write ? PEND_WR : PEND_RD;
                nxt.bus   = evt.cpu_write ? BUS_RDX : BUS_RD;
            end
        end
    end
endmodule

// File: rtl/msi_ctl_reg.sv
module msi_ctl_reg
    import msi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  line_ctl_t d,
    output line_ctl_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.state <= ST_I;
            q.pend  <= PEND_NONE;
            q.bus   <= BUS_NONE;
            q.wb    <= 1'b0;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
    import msi_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cpu_valid,
    input  logic               cpu_write,
    input  logic               cpu_hit,
    input  logic               cpu_evict,
    input  logic               snp_valid,
    input  logic               snp_write,
    input  logic               snp_match,
    input  logic               fill_done,
    output logic [STATE_W-1:0] line_state,
    output logic [BUS_W-1:0]   bus_req,
    output logic               wb_req,
    output logic               busy
);
    line_evt_t evt;
    line_ctl_t ctl_q;
    line_ctl_t ctl_d;

    msi_evt_pack u_pack (
        .cpu_valid (cpu_valid),
        .cpu_write (cpu_write),
        .cpu_hit   (cpu_hit),
        .cpu_evict (cpu_evict),
        .snp_valid (snp_valid),
        .snp_write (snp_write),
        .snp_match (snp_match),
        .fill_done (fill_done),
        .evt       (evt)
    );

    msi_next_ctl u_next (
        .cur (ctl_q),
        .evt (evt),
        .nxt (ctl_d)
    );

    msi_ctl_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (ctl_d),
        .q   (ctl_q)
    );

    assign line_state = ctl_q.state;
    assign bus_req    = ctl_q.bus;
    assign wb_req     = ctl_q.wb;
    assign busy       = (ctl_q.pend != PEND_NONE);

    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        line_state != 2'b11); // R1
    AST_RD_WAITS: assert property (@(posedge clk) disable iff (rst)
        bus_req == BUS_RD |-> busy); // R2
    AST_RDX_WAITS: assert property (@(posedge clk) disable iff (rst)
        bus_req == BUS_RDX |-> busy); // R3
    AST_UPG_LANDS_M: assert property (@(posedge clk) disable iff (rst)
        bus_req == BUS_UPG |-> (line_state == ST_M && !busy)); // R4
    AST_M_HIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!busy && line_state == ST_M && cpu_valid && cpu_hit && !cpu_evict
         && !(snp_valid && snp_match))
        |=> (bus_req == BUS_NONE && !wb_req && line_state == ST_M)); // R5
    AST_WB_FROM_M: assert property (@(posedge clk) disable iff (rst)
        wb_req |-> $past(line_state) == ST_M); // R6
    AST_SNWR_INVAL: assert property (@(posedge clk) disable iff (rst)
        (!busy && snp_valid && snp_match && snp_write) |=> line_state == ST_I); // R7
    AST_PEND_INVALID: assert property (@(posedge clk) disable iff (rst)
        busy |-> line_state == ST_I); // R11
endmodule

// File: tb/sim_msi_line_ctrl.sv
module sim_msi_line_ctrl;
    logic       clk = 1'b0;
    logic       rst;
    logic       cpu_valid, cpu_write, cpu_hit, cpu_evict;
    logic       snp_valid, snp_write, snp_match, fill_done;
    logic [1:0] line_state;
    logic [1:0] bus_req;
    logic       wb_req;
    logic       busy;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    msi_line_ctrl u0 (
        .clk(clk), .rst(rst),
        .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_hit(cpu_hit),
        .cpu_evict(cpu_evict), .snp_valid(snp_valid), .snp_write(snp_write),
        .snp_match(snp_match), .fill_done(fill_done),
        .line_state(line_state), .bus_req(bus_req), .wb_req(wb_req), .busy(busy)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic clr();
        {cpu_valid, cpu_write, cpu_hit, cpu_evict} = 4'b0;
        {snp_valid, snp_write, snp_match, fill_done} = 4'b0;
    endtask

    // inputs applied at a falling edge, results sampled at the next falling edge
    task automatic step(input logic cv, cw, ch, ev, sv, sw, sm, fd);
        cpu_valid = cv; cpu_write = cw; cpu_hit = ch; cpu_evict = ev;
        snp_valid = sv; snp_write = sw; snp_match = sm; fill_done = fd;
        @(posedge clk);
        @(negedge clk);
        clr();
    endtask

    task automatic do_reset();
        clr();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apply_op(input int op);
        case (op)
            0:  step(1, 0, 1, 0, 0, 0, 0, 0);
            1:  step(1, 0, 0, 0, 0, 0, 0, 0);
            2:  step(1, 1, 1, 0, 0, 0, 0, 0);
            3:  step(1, 1, 0, 0, 0, 0, 0, 0);
            4:  step(0, 0, 0, 1, 0, 0, 0, 0);
            5:  step(0, 0, 0, 0, 1, 0, 1, 0);
            6:  step(0, 0, 0, 0, 1, 1, 1, 0);
            7:  step(0, 0, 0, 0, 1, 1, 0, 0);
            8:  step(1, 1, 1, 0, 1, 0, 1, 0);
            9:  step(0, 0, 0, 0, 0, 0, 0, 1);
            default: step(1, 1, 1, 1, 0, 0, 0, 0);
        endcase
    endtask

    task automatic goto_state(input int st);
        do_reset();
        if (st == 1) begin
            step(1, 0, 0, 0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0, 0, 0, 1);
        end else if (st == 2) begin
            step(1, 1, 0, 0, 0, 0, 0, 0);
            step(0, 0, 0, 0, 0, 0, 0, 1);
        end
    endtask

    // Expected outcome from the requirements: ops 0 rd hit, 1 rd miss, 2 wr hit,
    // 3 wr miss, 4 evict, 5 snoop rd, 6 snoop wr, 7 unmatched snoop,
    // 8 snoop rd with wr hit, 9 stray fill, 10 evict with wr hit
    task automatic expect_op(input int st, input int op, output int e_st,
                             output int e_bus, output int e_wb, output int e_busy,
                             output int e_fin, output string rq);
        bit hit;
        e_st = st; e_bus = 0; e_wb = 0; e_busy = 0; e_fin = st; rq = "R5";
        case (op)
            0, 1: begin
                hit = (op == 0) && (st != 0);
                if (!hit) begin
                    e_bus = 1; e_wb = (st == 2) ? 1 : 0; e_st = 0; e_busy = 1; e_fin = 1;
                    rq = (st == 0 || op == 0) ? "R2" : "R9";
                end
            end
            2, 3: begin
                hit = (op == 2) && (st != 0);
                if (hit && st == 1) begin
                    e_bus = 3; e_st = 2; e_fin = 2; rq = "R4";
                end else if (!hit) begin
                    e_bus = 2; e_wb = (st == 2) ? 1 : 0; e_st = 0; e_busy = 1; e_fin = 2;
                    rq = (st == 0) ? "R3" : "R9";
                end
            end
            4: begin e_wb = (st == 2) ? 1 : 0; e_st = 0; e_fin = 0; rq = "R8"; end
            10: begin e_wb = (st == 2) ? 1 : 0; e_st = 0; e_fin = 0; rq = "R10"; end
            5, 8: begin
                rq = (op == 5) ? "R6" : "R10";
                if (st == 2) begin e_wb = 1; e_st = 1; e_fin = 1; end
            end
            6: begin
                rq = "R7";
                if (st != 0) begin e_wb = (st == 2) ? 1 : 0; e_st = 0; e_fin = 0; end
            end
            default: rq = "R11";
        endcase
    endtask

    initial begin
        int e_st, e_bus, e_wb, e_busy, e_fin;
        string rq;
        do_reset();
        chk("R1", "reset state", int'(line_state), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset bus_req", int'(bus_req), 0);
        chk("R1", "reset wb_req", int'(wb_req), 0);
        for (int st = 0; st < 3; st++) begin
            for (int op = 0; op < 11; op++) begin
                goto_state(st);
                chk("R1", "start state", int'(line_state), st);
                expect_op(st, op, e_st, e_bus, e_wb, e_busy, e_fin, rq);
                apply_op(op);
                chk(rq, $sformatf("st%0d op%0d state", st, op), int'(line_state), e_st);
                chk(rq, $sformatf("st%0d op%0d bus_req", st, op), int'(bus_req), e_bus);
                chk(rq, $sformatf("st%0d op%0d wb_req", st, op), int'(wb_req), e_wb);
                chk(rq, $sformatf("st%0d op%0d busy", st, op), int'(busy), e_busy);
                if (e_busy == 1) begin
                    step(1, 1, 1, 1, 1, 1, 1, 0);
                    chk("R11", "pending ignores inputs state", int'(line_state), 0);
                    chk("R11", "pending ignores inputs busy", int'(busy), 1);
                    chk("R12", "pending no bus pulse", int'(bus_req), 0);
                    chk("R11", "pending no wb", int'(wb_req), 0);
                    step(0, 0, 0, 0, 0, 0, 0, 1);
                    chk(rq, "state after fill", int'(line_state), e_fin);
                    chk(rq, "busy after fill", int'(busy), 0);
                end else begin
                    step(0, 0, 0, 0, 0, 0, 0, 0);
                    chk("R12", "bus_req one cycle", int'(bus_req), 0);
                    chk("R12", "wb_req one cycle", int'(wb_req), 0);
                    chk(rq, "state held", int'(line_state), e_fin);
                end
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule